// File: doc/BRIEF.md
# Per-Lane Read Capture and Realignment

This block takes read data from a DRAM byte by byte, where each byte lane comes with its own strobe. The DRAM drives each strobe with its edges lined up with the data. A lane captures one byte on the rising strobe edge and one on the falling edge. The two bytes form a beat pair, which is placed in a small per-lane slot ring inside the strobe domain. Only the ring's write pointer, Gray coded, crosses into the controller clock domain through a short synchronizer. Each lane therefore settles on its own, and lanes may arrive up to one controller clock apart and drift over time.

The controller pulses `beat_expect` once for every beat pair it expects. When every lane holds an unread pair, the pairs are combined into one registered word and `word_valid` pulses for one clock. Read data passes straight from the lane slots to that output register, with no further staging. If an expected pair is not complete in time, the block raises a one-clock timeout pulse.

Top module: `rdsync_top`

## Requirements
- R1: While `rst` is high and on the first clock after it, `word_valid` and `beat_timeout` are 0, and `word_data` is 0 after reset.
- R2: A lane latches its byte on the rising edge of its strobe and latches the next byte on the falling edge. In `word_data`, lane l occupies bits [16l+15:16l]: its low byte is the rising-edge byte and its high byte is the falling-edge byte.
- R3: A lane that has finished a pair keeps it, and keeps signalling it, until every lane has finished the same pair. No lane's data is dropped while it waits for a late lane, even one that is very late.
- R4: `word_valid` pulses for exactly one clock for each pair. It pulses only when all lanes hold that pair, including when lanes arrive with different skews of up to one controller clock.
- R5: Back-to-back pairs, up to SLOTS-1 in flight per lane (default 3), come out in the order they were strobed.
- R6: If a pair announced with `beat_expect` is not delivered within TMO_LIMIT clocks (SYNC_STAGES+4+SLACK_CLKS, default 8), `beat_timeout` pulses for exactly one clock, never in the same cycle as `word_valid`. It does not pulse again until a delivery restarts the wait.
- R7: If every expected pair arrives in time, `beat_timeout` stays 0.
- R8: `word_data` holds its value on every clock where `word_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset (strobes must pulse once while it is high) |
| rd_dq | input | LANES*8 | Read data; lane l on bits [8l+7:8l] |
| rd_dqs | input | LANES | One edge-aligned strobe per lane |
| beat_expect | input | 1 | One pulse per beat pair the controller expects |
| word_data | output | LANES*16 | Realigned word, registered |
| word_valid | output | 1 | One-clock pulse when `word_data` carries a new word |
| beat_timeout | output | 1 | One-clock pulse when an expected pair is late |

## Verification
The bench drives lanes with ramped skews, reversed skews and alternating skews of nearly a full clock. A design that combined lanes on a fixed cycle instead of per-lane readiness would mix bytes from neighbouring pairs. Bursts of three pairs check ordering, which breaks if the ring pointer or its Gray crossing is wrong. One lane held back for twenty clocks must cause exactly one timeout pulse and must still yield the correct word later. This catches a timer that repeats, a timer that never fires, and a lane that loses its pair while waiting. The bench also checks that the word does not change between valid pulses.

// File: rtl/rdsync_pkg.sv
`timescale 1ns/1ps
package rdsync_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic [BYTE_W-1:0] fall;
    logic [BYTE_W-1:0] rise;
  } beat_pair_t;
endpackage

// File: rtl/rdsync_lane.sv
`timescale 1ns/1ps
module rdsync_lane
  import rdsync_pkg::*;
#(
  parameter int SLOTS       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dqs,
  input  logic [BYTE_W-1:0] dq,
  input  logic              advance,
  output logic              ready,
  output beat_pair_t        pair
);
  localparam int PW = $clog2(SLOTS);

  logic [BYTE_W-1:0] rise_q;
  beat_pair_t        ring [SLOTS];
  logic [PW-1:0]     wp_bin, wp_gray, wp_next;
  logic [PW-1:0]     sync_q [SYNC_STAGES];
  logic [PW-1:0]     rp;

  assign wp_next = wp_bin + 1'b1;

  // strobe domain: rising edge byte
  always_ff @(posedge dqs) begin
    rise_q <= dq;
  end

  // strobe domain: falling edge completes the pair
  always_ff @(negedge dqs) begin
    if (rst) begin
      wp_bin  <= '0;
      wp_gray <= '0;
    end else begin
      wp_bin  <= wp_next;
      wp_gray <= wp_next ^ (wp_next >> 1);
    end
  end

  always_ff @(negedge dqs) begin
    if (!rst) ring[wp_bin] <= '{fall: dq, rise: rise_q};
  end

  // controller domain: pointer synchronizer
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= wp_gray;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rp <= '0;
    else if (advance) rp <= rp + 1'b1;
  end

  assign ready = ((rp ^ (rp >> 1)) != sync_q[SYNC_STAGES-1]);
  assign pair  = ring[rp];
endmodule

// File: rtl/rdsync_timer.sv
`timescale 1ns/1ps
module rdsync_timer #(
  parameter int PENDW = 3,
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic expect_i,
  input  logic deliver_i,
  output logic late_o
);
  localparam int AW = $clog2(LIMIT + 1);

  logic [PENDW-1:0] pend;
  logic [AW-1:0]    age;
  logic             dec;

  assign dec = deliver_i && ((pend != '0) || expect_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend   <= '0;
      age    <= '0;
      late_o <= 1'b0;
    end else begin
      pend <= pend + PENDW'(expect_i) - PENDW'(dec);
      if (pend == '0 || deliver_i)  age <= '0;
      else if (age != AW'(LIMIT))   age <= age + 1'b1;
      late_o <= (pend != '0) && !deliver_i && (age == AW'(LIMIT - 1));
    end
  end
endmodule

// File: rtl/rdsync_top.sv
`timescale 1ns/1ps
module rdsync_top
  import rdsync_pkg::*;
#(
  parameter int LANES       = 8,
  parameter int SLOTS       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int SLACK_CLKS  = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [LANES*BYTE_W-1:0]    rd_dq,
  input  logic [LANES-1:0]           rd_dqs,
  input  logic                       beat_expect,
  output logic [LANES*2*BYTE_W-1:0]  word_data,
  output logic                       word_valid,
  output logic                       beat_timeout
);
  localparam int PAIR_W    = 2 * BYTE_W;
  localparam int TMO_LIMIT = SYNC_STAGES + 4 + SLACK_CLKS;
  localparam int PENDW     = $clog2(SLOTS) + 1;

  logic [LANES-1:0] lane_ready;
  beat_pair_t       lane_pair [LANES];
  logic             deliver;

  assign deliver = &lane_ready;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    rdsync_lane #(
      .SLOTS(SLOTS),
      .SYNC_STAGES(SYNC_STAGES)
    ) u_lane (
      .clk(clk),
      .rst(rst),
      .dqs(rd_dqs[g]),
      .dq(rd_dq[g*BYTE_W +: BYTE_W]),
      .advance(deliver),
      .ready(lane_ready[g]),
      .pair(lane_pair[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_data  <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= deliver;
      if (deliver)
        for (int l = 0; l < LANES; l++) word_data[l*PAIR_W +: PAIR_W] <= lane_pair[l];
    end
  end

  rdsync_timer #(
    .PENDW(PENDW),
    .LIMIT(TMO_LIMIT)
  ) u_timer (
    .clk(clk),
    .rst(rst),
    .expect_i(beat_expect),
    .deliver_i(deliver),
    .late_o(beat_timeout)
  );
endmodule

// File: rtl/rdsync_chk.sv
`timescale 1ns/1ps
module rdsync_chk #(
  parameter int LANES = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             word_valid,
  input logic             beat_timeout,
  input logic [LANES-1:0] lane_ready
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!word_valid && !beat_timeout));

  a_r4_full_word: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> $past(&lane_ready));

  a_r3_lane_holds: assert property (@(posedge clk) disable iff (rst)
    !(&lane_ready) |=> ((lane_ready & $past(lane_ready)) == $past(lane_ready)));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    beat_timeout |=> !beat_timeout);

  a_r6_not_with_word: assert property (@(posedge clk) disable iff (rst)
    beat_timeout |-> !word_valid);
endmodule

bind rdsync_top rdsync_chk #(.LANES(LANES)) u_chk (
  .clk(clk),
  .rst(rst),
  .word_valid(word_valid),
  .beat_timeout(beat_timeout),
  .lane_ready(lane_ready)
);

// File: tb/sim_rdsync_top.sv
`timescale 1ns/1ps
module sim_rdsync_top;
  localparam int CLK_NS = 10;
  localparam int LANES  = 8;
  localparam int DW     = LANES * 8;
  localparam int WW     = 2 * DW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic beat_expect = 1'b0;
  logic [7:0] dq_l [LANES];
  logic       dqs_l [LANES];
  logic [DW-1:0]    rd_dq;
  logic [LANES-1:0] rd_dqs;
  logic [WW-1:0]    word_data;
  logic             word_valid, beat_timeout;

  int errors = 0, checks = 0, err_pulses = 0, hold_bad = 0, seq = 0;
  int skew_ns [LANES];
  logic [WW-1:0] sb [$];
  logic [WW-1:0] last_word = '0;
  logic [WW-1:0] exp_w;

  always #(CLK_NS/2) clk = ~clk;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      rd_dq[l*8 +: 8] = dq_l[l];
      rd_dqs[l]       = dqs_l[l];
    end
  end

  rdsync_top u0 (
    .clk(clk), .rst(rst), .rd_dq(rd_dq), .rd_dqs(rd_dqs),
    .beat_expect(beat_expect), .word_data(word_data),
    .word_valid(word_valid), .beat_timeout(beat_timeout)
  );

  function automatic logic [7:0] beat_byte(int s, int l, int e);
    return 8'((s * 37 + l * 11 + e * 91 + 3) & 255);
  endfunction

  task automatic check(bit ok, string req, logic [WW-1:0] act, logic [WW-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic drive_lane(int l, int s0, int n);
    #(skew_ns[l]);
    for (int k = 0; k < n; k++) begin
      dq_l[l] = beat_byte(s0 + k, l, 0);
      #1 dqs_l[l] = 1'b1;
      #4 dq_l[l] = beat_byte(s0 + k, l, 1);
      #1 dqs_l[l] = 1'b0;
      #4;
    end
  endtask

  // driver: pushes expected words, strobes lanes, announces pairs
  task automatic run_burst(int n);
    for (int k = 0; k < n; k++) begin
      logic [WW-1:0] w;
      for (int l = 0; l < LANES; l++) begin
        w[l*16 +: 8]     = beat_byte(seq + k, l, 0);
        w[l*16 + 8 +: 8] = beat_byte(seq + k, l, 1);
      end
      sb.push_back(w);
    end
    @(negedge clk);
    for (int l = 0; l < LANES; l++) begin
      automatic int ll = l;
      automatic int ss = seq;
      fork drive_lane(ll, ss, n); join_none
    end
    for (int k = 0; k < n; k++) begin
      beat_expect = 1'b1;
      @(negedge clk);
    end
    beat_expect = 1'b0;
    wait fork;
    seq += n;
    repeat (12) @(negedge clk);
  endtask

  // monitor: pops and compares (R2 byte layout, R4 full word, R5 order)
  always @(negedge clk) begin
    if (!rst) begin
      if (word_valid) begin
        if (sb.size() == 0) check(1'b0, "R4 word with nothing expected", word_data, '0);
        else begin
          exp_w = sb.pop_front();
          check(word_data == exp_w, "R2 R4 R5 word content", word_data, exp_w);
        end
        last_word = word_data;
      end else if (word_data != last_word) hold_bad++;
      if (beat_timeout) err_pulses++;
    end
  end

  initial begin
    #(CLK_NS * 20000);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    for (int l = 0; l < LANES; l++) begin dq_l[l] = '0; dqs_l[l] = 1'b0; skew_ns[l] = 0; end
    repeat (2) @(negedge clk);
    for (int l = 0; l < LANES; l++) dqs_l[l] = 1'b1;
    #2;
    for (int l = 0; l < LANES; l++) dqs_l[l] = 1'b0;
    repeat (3) @(negedge clk);
    check(word_valid == 1'b0, "R1 valid in reset", WW'(word_valid), '0);
    check(beat_timeout == 1'b0, "R1 timeout in reset", WW'(beat_timeout), '0);
    rst = 1'b0;
    @(negedge clk);
    check(word_data == '0, "R1 word after reset", word_data, '0);
    check(word_valid == 1'b0, "R1 valid after reset", WW'(word_valid), '0);
    repeat (2) @(negedge clk);

    run_burst(1);                                           // aligned lanes
    for (int l = 0; l < LANES; l++) skew_ns[l] = l;         // ramped skew
    run_burst(1);
    for (int l = 0; l < LANES; l++) skew_ns[l] = 9 - l;     // reversed skew
    run_burst(2);
    for (int l = 0; l < LANES; l++) skew_ns[l] = (l % 2) * 9; // R5 burst, alternating
    run_burst(3);
    check(sb.size() == 0, "R5 all burst words out", WW'(sb.size()), '0);
    check(err_pulses == 0, "R7 no timeout when on time", WW'(err_pulses), '0);

    for (int l = 0; l < LANES; l++) skew_ns[l] = 0;
    skew_ns[3] = 200;                                       // R6 one late lane
    run_burst(1);
    check(err_pulses == 1, "R6 single timeout pulse", WW'(err_pulses), WW'(1));
    check(sb.size() == 0, "R3 late lane word delivered", WW'(sb.size()), '0);

    skew_ns[3] = 4;
    run_burst(2);
    check(err_pulses == 1, "R6 no repeat after recovery", WW'(err_pulses), WW'(1));
    check(sb.size() == 0, "R4 recovery words out", WW'(sb.size()), '0);
    check(hold_bad == 0, "R8 word held between pulses", WW'(hold_bad), '0);
    finish_run();
  end
endmodule